// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block sits on the receive byte stream of an Ethernet MAC. A software write arms a wake-hunting mode. While the mode is armed and reception is enabled, nothing is forwarded to the host. Every incoming frame is searched for a wake pattern and then dropped. The pattern is a run of 0xFF bytes followed by repeated copies of the station's own 48-bit address.

When a frame that holds the pattern ends with its good flag set, the block clears its own arm bit. It also sets a sticky event bit, and that bit drives an interrupt through a mask. Software may arm the block only after both transmit and receive have been gracefully stopped. An arm write made at any other time is dropped.

When the block is not armed, received bytes and their frame flags pass straight through to the host path.

Top module: `magic_wake_detector`

## Requirements
- R1: After reset, `armed`, `wake_evt`, `wake_mask` and `irq` are all 0.
- R2: A write (`cfg_wr`=1) with `cfg_arm`=1 sets `armed` only if `rx_stop_done` and `tx_stop_done` are both 1 in that cycle; otherwise it is ignored. A write with `cfg_arm`=0 clears `armed`.
- R3: While `armed` is 0, `host_valid` equals `rx_valid & rx_en` and `host_data` equals `rx_data`. While `armed` is 1, `host_valid` is 0 and every frame is dropped.
- R4: The wake pattern is at least 6 consecutive 0xFF bytes followed directly by 16 back-to-back copies of `station_addr`, sent most significant byte first (bits 47:40 first). It may start at any byte offset in the frame. Extra leading 0xFF bytes and trailing bytes are allowed. Fewer than 6 0xFF bytes, or fewer than 16 copies, is no match. The first address byte must not be 0xFF.
- R5: Hunting happens only while `armed` and `rx_en` are both 1. A pattern received with `rx_en`=0 leaves `armed` set and `wake_evt` clear.
- R6: A pattern counts only if the frame's end byte (`rx_eof`=1) carries `rx_good`=1. A pattern in a bad frame leaves the block armed with no event.
- R7: On a valid detection, the clock edge that samples the end byte clears `armed` and sets `wake_evt`.
- R8: `wake_evt` is sticky. It is cleared by a pulse on `evt_clr` (write-1-to-clear). A detection in the same cycle as a clear leaves it set.
- R9: `irq` equals `wake_evt & wake_mask`. `wake_mask` loads `mask_in` when `mask_wr` is 1.
- R10: The search state restarts at each start-of-frame, so a pattern split across two frames is not detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Frame reception enabled |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_sof | input | 1 | First byte of frame |
| rx_eof | input | 1 | Last byte of frame |
| rx_good | input | 1 | Frame good, sampled with the last byte |
| station_addr | input | 48 | Station address |
| rx_stop_done | input | 1 | Graceful receive stop completed |
| tx_stop_done | input | 1 | Graceful transmit stop completed |
| cfg_wr | input | 1 | Arm-bit write strobe |
| cfg_arm | input | 1 | Arm-bit write value |
| evt_clr | input | 1 | Write-1-to-clear for the event bit |
| mask_wr | input | 1 | Mask write strobe |
| mask_in | input | 1 | Mask write value |
| armed | output | 1 | Arm status |
| wake_evt | output | 1 | Sticky wake event |
| wake_mask | output | 1 | Interrupt mask |
| irq | output | 1 | Interrupt (event AND mask) |
| host_valid | output | 1 | Forwarded byte valid |
| host_data | output | 8 | Forwarded byte |
| host_sof | output | 1 | Forwarded start-of-frame |
| host_eof | output | 1 | Forwarded end-of-frame |
| host_good | output | 1 | Forwarded frame-good |

## Verification
The bench sweeps the length of the 0xFF run and the number of address copies on each side of their thresholds. A design with an off-by-one in either count would then wake on a short pattern or miss a valid one. It also sends bad frames, frames with reception disabled, and a pattern split across two frames. A design that ignored the good flag, the enable, or the restart at frame start would wake on one of these when it should not. Further tests cover arm writes made while a stop-done input is low, and an event clear that lands in the same cycle as a detection. These would catch a block that arms without the graceful-stop handshake, or one that loses a wake event.

// File: rtl/magic_wake_detector.sv
module magic_wake_detector #(
  parameter int SYNC_LEN   = 6,
  parameter int COPIES     = 16,
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_en,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  input  logic                    rx_sof,
  input  logic                    rx_eof,
  input  logic                    rx_good,
  input  logic [ADDR_BYTES*8-1:0] station_addr,
  input  logic                    rx_stop_done,
  input  logic                    tx_stop_done,
  input  logic                    cfg_wr,
  input  logic                    cfg_arm,
  input  logic                    evt_clr,
  input  logic                    mask_wr,
  input  logic                    mask_in,
  output logic                    armed,
  output logic                    wake_evt,
  output logic                    wake_mask,
  output logic                    irq,
  output logic                    host_valid,
  output logic [7:0]              host_data,
  output logic                    host_sof,
  output logic                    host_eof,
  output logic                    host_good
);

  localparam int SW = $clog2(SYNC_LEN + 1);
  localparam int BW = $clog2(ADDR_BYTES);
  localparam int CW = $clog2(COPIES);

  logic [SW-1:0] ff_run, b_run, n_run;
  logic          in_addr, b_in, n_in;
  logic [BW-1:0] byte_idx, b_idx, n_idx;
  logic [CW-1:0] copy_cnt, b_cnt, n_cnt;
  logic          found, b_found, n_found;
  logic [7:0]    cur_addr, first_addr;
  logic          hunting, is_ff, detect;

  assign hunting    = armed & rx_en;
  assign is_ff      = rx_data == 8'hFF;
  assign first_addr = station_addr[ADDR_BYTES*8-1 -: 8];

  assign b_run   = rx_sof ? '0 : ff_run;
  assign b_in    = rx_sof ? 1'b0 : in_addr;
  assign b_idx   = rx_sof ? '0 : byte_idx;
  assign b_cnt   = rx_sof ? '0 : copy_cnt;
  assign b_found = rx_sof ? 1'b0 : found;

  assign cur_addr = station_addr[(ADDR_BYTES - 1 - int'(b_idx)) * 8 +: 8];

  always_comb begin
    n_run   = b_run;
    n_in    = b_in;
    n_idx   = b_idx;
    n_cnt   = b_cnt;
    n_found = b_found;
    if (!b_in) begin
      if (is_ff) begin
        if (b_run != SW'(SYNC_LEN)) n_run = b_run + 1'b1;
      end else if (b_run == SW'(SYNC_LEN) && rx_data == first_addr) begin
        n_in  = 1'b1;
        n_idx = BW'(1);
        n_cnt = '0;
        n_run = '0;
      end else begin
        n_run = '0;
      end
    end else if (rx_data == cur_addr) begin
      if (b_idx == BW'(ADDR_BYTES - 1)) begin
        n_idx = '0;
        if (b_cnt == CW'(COPIES - 1)) begin
          n_found = 1'b1;
          n_in    = 1'b0;
          n_cnt   = '0;
        end else begin
          n_cnt = b_cnt + 1'b1;
        end
      end else begin
        n_idx = b_idx + 1'b1;
      end
    end else begin
      n_in  = 1'b0;
      n_idx = '0;
      n_cnt = '0;
      n_run = is_ff ? SW'(1) : '0;
    end
  end

  assign detect = hunting & rx_valid & rx_eof & rx_good & n_found;

  always_ff @(posedge clk) begin
    if (!rst_n || !hunting) begin
      ff_run   <= '0;
      in_addr  <= 1'b0;
      byte_idx <= '0;
      copy_cnt <= '0;
      found    <= 1'b0;
    end else if (rx_valid) begin
      ff_run   <= n_run;
      in_addr  <= n_in;
      byte_idx <= n_idx;
      copy_cnt <= n_cnt;
      found    <= n_found;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      wake_evt  <= 1'b0;
      wake_mask <= 1'b0;
    end else begin
      if (detect)
        armed <= 1'b0;
      else if (cfg_wr && !cfg_arm)
        armed <= 1'b0;
      else if (cfg_wr && rx_stop_done && tx_stop_done)
        armed <= 1'b1;
      if (detect)       wake_evt <= 1'b1;
      else if (evt_clr) wake_evt <= 1'b0;
      if (mask_wr) wake_mask <= mask_in;
    end
  end

  assign irq        = wake_evt & wake_mask;
  assign host_valid = rx_valid & rx_en & ~armed;
  assign host_data  = rx_data;
  assign host_sof   = host_valid & rx_sof;
  assign host_eof   = host_valid & rx_eof;
  assign host_good  = host_valid & rx_eof & rx_good;

  AST_ARM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(cfg_wr && cfg_arm && rx_stop_done && tx_stop_done)); // R2
  AST_DISARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(armed) |-> (wake_evt || $past(cfg_wr && !cfg_arm))); // R7
  AST_EVT_GOOD_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_evt) |-> $past(rx_valid && rx_eof && rx_good)); // R6
  AST_EVT_NEEDS_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_evt) |-> $past(armed && rx_en)); // R5
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wake_evt) && !$past(evt_clr)) |-> wake_evt); // R8

endmodule

// File: tb/magic_wake_detector_tb.sv
module magic_wake_detector_tb;
  logic clk = 0, rst_n = 0;
  logic rx_en = 1, rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_good = 0;
  logic [7:0] rx_data = 0;
  logic [47:0] station_addr = 48'h02_A1_B2_C3_FF_D4;
  logic rx_stop_done = 1, tx_stop_done = 1, cfg_wr = 0, cfg_arm = 0;
  logic evt_clr = 0, mask_wr = 0, mask_in = 0;
  logic armed, wake_evt, wake_mask, irq, host_valid, host_sof, host_eof, host_good;
  logic [7:0] host_data;
  int checks = 0, errors = 0;
  logic [7:0] frm [512];
  int len;

  always #10 clk = ~clk;

  magic_wake_detector u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_arm(input logic v);
    @(negedge clk); cfg_wr = 1; cfg_arm = v;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic clr_evt();
    @(negedge clk); evt_clr = 1;
    @(negedge clk); evt_clr = 0;
  endtask

  task automatic build(input int junk, input int nff, input int ncp, input int tail);
    len = 0;
    for (int i = 0; i < junk; i++) begin frm[len] = 8'h11 + 8'(i); len++; end
    for (int i = 0; i < nff; i++) begin frm[len] = 8'hFF; len++; end
    for (int c = 0; c < ncp; c++)
      for (int k = 0; k < 6; k++) begin frm[len] = station_addr[47-8*k -: 8]; len++; end
    for (int i = 0; i < tail; i++) begin frm[len] = 8'h5A; len++; end
  endtask

  task automatic send(input logic good, input logic clr_at_end);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = frm[i]; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_good = (i == len - 1) ? good : 1'b0;
      evt_clr = clr_at_end && (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0; evt_clr = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 armed", armed, 0); chk("R1 evt", wake_evt, 0);
    chk("R1 mask", wake_mask, 0); chk("R1 irq", irq, 0);

    // R3 forwarding while idle
    rx_valid = 1; rx_data = 8'h3C; rx_sof = 1; #1;
    chk("R3 fwd valid", host_valid, 1); chk("R3 fwd data", host_data, 8'h3C);
    chk("R3 fwd sof", host_sof, 1);
    @(negedge clk); rx_valid = 0; rx_sof = 0;

    // R2 gated arming
    rx_stop_done = 0; wr_arm(1); chk("R2 rx not stopped", armed, 0);
    rx_stop_done = 1; tx_stop_done = 0; wr_arm(1); chk("R2 tx not stopped", armed, 0);
    tx_stop_done = 1; wr_arm(1); chk("R2 arm ok", armed, 1);
    wr_arm(0); chk("R2 disarm write", armed, 0);
    wr_arm(1);

    // R3 drop while armed
    @(negedge clk); rx_valid = 1; rx_data = 8'h3C; #1;
    chk("R3 drop armed", host_valid, 0);
    @(negedge clk); rx_valid = 0;

    // R4 sweep FF run length
    for (int n = 0; n <= 8; n++) begin
      if (!armed) wr_arm(1);
      if (wake_evt) clr_evt();
      build(3, n, 16, 2); send(1, 0);
      chk("R4 ff sweep armed", armed, (n >= 6) ? 0 : 1);
      chk("R4 ff sweep evt", wake_evt, (n >= 6) ? 1 : 0);
    end
    // R4 sweep copy count, R7 timing at frame end
    for (int c = 0; c <= 17; c++) begin
      if (!armed) wr_arm(1);
      if (wake_evt) clr_evt();
      build(0, 6, c, 0); send(1, 0);
      chk("R7 copy sweep armed", armed, (c >= 16) ? 0 : 1);
      chk("R4 copy sweep evt", wake_evt, (c >= 16) ? 1 : 0);
    end

    // R6 bad frame
    wr_arm(1); clr_evt();
    build(5, 7, 16, 4); send(0, 0);
    chk("R6 bad armed", armed, 1); chk("R6 bad evt", wake_evt, 0);

    // R5 reception disabled
    rx_en = 0; build(0, 6, 16, 0); send(1, 0);
    chk("R5 rxdis armed", armed, 1); chk("R5 rxdis evt", wake_evt, 0);
    rx_en = 1;

    // R10 split across frames
    build(0, 6, 8, 0); send(1, 0);
    build(0, 0, 8, 0); send(1, 0);
    chk("R10 split armed", armed, 1); chk("R10 split evt", wake_evt, 0);

    // R9 mask and irq
    build(0, 6, 16, 0); send(1, 0);
    chk("R9 irq masked", irq, 0);
    @(negedge clk); mask_wr = 1; mask_in = 1; @(negedge clk); mask_wr = 0;
    chk("R9 mask set", wake_mask, 1); chk("R9 irq on", irq, 1);

    // R8 clear and set-wins
    clr_evt(); chk("R8 w1c", wake_evt, 0); chk("R9 irq off", irq, 0);
    wr_arm(1); build(1, 6, 16, 1); send(1, 1);
    chk("R8 set wins", wake_evt, 1);
    repeat (3) @(negedge clk);
    chk("R8 sticky", wake_evt, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule